// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early-Warning Flag

This block supervises software with a 7-bit down-counter that runs once the watchdog has been switched on. Software keeps the system alive by rewriting the counter. That rewrite is only legal while the counter has already fallen to or below a programmable window bound. A rewrite made while the counter is still above the bound counts as a fault. Letting the counter drop from 0x40 to 0x3F is also a fault. Either fault raises a one-cycle reset request.

When the counter reaches 0x40, the block sets a warning flag. Software can use the warning to do a last-moment rewrite or to save state. The flag raises the interrupt output only when the warning interrupt has been enabled. The flag is set either way, and only a write of zero clears it.

Three 32-bit registers on a simple register bus hold the counter, the configuration and the flag. They sit at byte offsets 0x0, 0x4 and 0x8. The counting rate is a base divider, the parameter DIV_BASE, scaled by a power of two that software selects.

Top module: `window_watchdog`

## Requirements
- R1: After reset, the control word reads 0x0000007F, the configuration word reads 0x0000007F and the status word reads 0x00000000. Both rst_req and irq are low.
- R2: Read layout, selected by bus_addr[3:2]:
  - Control (word 0): bits 6:0 hold the counter and bit 7 holds the active bit.
  - Configuration (word 1): bits 6:0 hold the window bound, bit 9 holds the warning-interrupt enable and bits 12:10 hold the rate select. Bits 8:7 and every other unlisted bit read 0.
  - Status (word 2): bit 0 holds the warning flag.
  - Word 3 reads 0.
- R3: Writing 1 to control bit 7 makes the watchdog active. Writing 0 there never clears it; only reset does. While inactive, the counter does not decrement.
- R4: While active, the counter decrements once every DIV_BASE·2^sel clock cycles, where sel is configuration bits 12:10. The first decrement comes that many cycles after the activating write. If sel is lowered so that the elapsed phase already exceeds the new period, the decrement happens at the next edge.
- R5: A control write while active and while the counter is greater than the window bound raises rst_req for exactly one cycle, starting at the write edge. The written counter value is still loaded. A write with the counter at or below the bound raises no request.
- R6: A decrement from 0x40 to 0x3F raises rst_req for exactly one cycle, starting at that edge.
- R7: A decrement from 0x41 to 0x40 sets the warning flag, whether or not the warning interrupt is enabled.
- R8: Writing status with bit 0 = 0 clears the flag; writing bit 0 = 1 has no effect. If a clear and a setting decrement fall on the same edge, the flag ends up set.
- R9: Writing 1 to configuration bit 9 enables the warning interrupt, and writing 0 does not disable it (only reset does). irq is high exactly while both the flag and the enable are 1.
- R10: A control write on the same edge as a due decrement loads the written value; the decrement for that period is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | AW | Byte address; bits AW-1:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr (combinational) |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Warning interrupt |

## Verification
Two pairs of events can land on the same edge:
- A software clear of the warning flag and the decrement that sets it.
- A counter rewrite and a due decrement.

The bench watches its reference model's prescaler phase and counter value. It places the status write of zero exactly on the edge where the model predicts the 0x41-to-0x40 step, and a control rewrite on an edge where a decrement is due. It then reads the flag back as set and the counter back as the written value, not one lower. Every cycle, the model's request, interrupt and read word are compared with the design's outputs.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  localparam int CNT_W = 7;
  localparam int SEL_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SEL_W-1:0] sel_t;

  // word indices on the register bus
  localparam int CTRL_WORD = 0;
  localparam int CFG_WORD  = 1;
  localparam int STAT_WORD = 2;

  // bit positions
  localparam int ACT_BIT  = CNT_W;
  localparam int IE_BIT   = 9;
  localparam int SEL_LSB  = 10;
  localparam int FLAG_BIT = 0;

  localparam cnt_t CNT_INIT = '1;
  localparam cnt_t WARN_VAL = cnt_t'(1 << (CNT_W - 1));
  localparam cnt_t PRE_WARN = cnt_t'(WARN_VAL + cnt_t'(1));

  // clock cycles per counter step
  function automatic logic [31:0] period_of(input int unsigned base, input int unsigned sh);
    return base << sh;
  endfunction

  // rewrite is early while the counter is still above the bound
  function automatic logic too_early(input cnt_t cnt, input cnt_t bound);
    return cnt > bound;
  endfunction

  function automatic logic [31:0] pack_ctrl(input cnt_t cnt, input logic act);
    logic [31:0] r;
    r = '0;
    r[CNT_W-1:0] = cnt;
    r[ACT_BIT] = act;
    return r;
  endfunction

  function automatic logic [31:0] pack_cfg(input cnt_t bound, input logic ie, input sel_t sel);
    logic [31:0] r;
    r = '0;
    r[CNT_W-1:0] = bound;
    r[IE_BIT] = ie;
    r[SEL_LSB +: SEL_W] = sel;
    return r;
  endfunction

  function automatic logic [31:0] pack_stat(input logic flag);
    logic [31:0] r;
    r = '0;
    r[FLAG_BIT] = flag;
    return r;
  endfunction

endpackage

// File: rtl/wwd_prescale.sv
module wwd_prescale
  import wwd_pkg::*;
#(
  parameter int unsigned DIV_BASE = 4096,
  parameter int LIM_W = $clog2(DIV_BASE) + (1 << SEL_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  sel_t sel,
  output logic tick
);

  logic [LIM_W-1:0] phase;
  logic [31:0] phase_ext;
  logic [31:0] last_phase;

  assign phase_ext  = {{(32-LIM_W){1'b0}}, phase};
  assign last_phase = period_of(DIV_BASE, {{(32-SEL_W){1'b0}}, sel}) - 32'd1;

  // a phase already past the period (after sel shrinks) fires at once
  assign tick = run && (phase_ext >= last_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (!run || tick)
      phase <= '0;
    else
      phase <= phase + LIM_W'(1);
  end

endmodule

// File: rtl/wwd_counter.sv
module wwd_counter
  import wwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  cnt_t wr_cnt,
  input  logic wr_act,
  input  logic tick,
  input  cnt_t bound,
  output cnt_t cnt,
  output logic act,
  output logic ev_early,
  output logic ev_warn,
  output logic ev_under,
  output logic rst_req
);

  logic step;

  // a rewrite on the same edge wins over the decrement
  assign step     = tick && !wr;
  assign ev_early = wr && act && too_early(cnt, bound);
  assign ev_warn  = step && (cnt == PRE_WARN);
  assign ev_under = step && (cnt == WARN_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CNT_INIT;
      act     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (wr)
        cnt <= wr_cnt;
      else if (step)
        cnt <= cnt - cnt_t'(1);
      act     <= act | (wr & wr_act);
      rst_req <= ev_early | ev_under;
    end
  end

endmodule

// File: rtl/wwd_cfgstat.sv
module wwd_cfgstat
  import wwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic stat_wr,
  input  cnt_t wr_bound,
  input  logic wr_ie,
  input  sel_t wr_sel,
  input  logic wr_flag,
  input  logic ev_warn,
  output cnt_t bound,
  output logic ie,
  output sel_t sel,
  output logic flag,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound <= CNT_INIT;
      ie    <= 1'b0;
      sel   <= '0;
    end else if (cfg_wr) begin
      bound <= wr_bound;
      ie    <= ie | wr_ie;
      sel   <= wr_sel;
    end
  end

  // setting has priority over a software clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (ev_warn)
      flag <= 1'b1;
    else if (stat_wr && !wr_flag)
      flag <= 1'b0;
  end

  assign irq = flag & ie;

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwd_pkg::*;
#(
  parameter int unsigned DIV_BASE = 4096,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          rst_req,
  output logic          irq
);

  localparam int WORD_W = AW - 2;
  localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(CTRL_WORD);
  localparam logic [WORD_W-1:0] W_CFG  = WORD_W'(CFG_WORD);
  localparam logic [WORD_W-1:0] W_STAT = WORD_W'(STAT_WORD);

  logic [WORD_W-1:0] word;
  logic ctrl_wr, cfg_wr, stat_wr;
  logic tick, act, ie, flag;
  logic ev_early, ev_warn, ev_under;
  cnt_t cnt, win;
  sel_t sel;
  logic unused_bits;

  assign word    = bus_addr[AW-1:2];
  assign ctrl_wr = bus_we && (word == W_CTRL);
  assign cfg_wr  = bus_we && (word == W_CFG);
  assign stat_wr = bus_we && (word == W_STAT);

  assign unused_bits = ^{bus_wdata[31:SEL_LSB+SEL_W], bus_wdata[IE_BIT-1:ACT_BIT+1], bus_addr[1:0]};

  wwd_prescale #(.DIV_BASE(DIV_BASE)) u_pre (
    .clk (clk),
    .rst_n (rst_n),
    .run (act),
    .sel (sel),
    .tick (tick)
  );

  wwd_counter u_cnt (
    .clk (clk),
    .rst_n (rst_n),
    .wr (ctrl_wr),
    .wr_cnt (bus_wdata[CNT_W-1:0]),
    .wr_act (bus_wdata[ACT_BIT]),
    .tick (tick),
    .bound (win),
    .cnt (cnt),
    .act (act),
    .ev_early (ev_early),
    .ev_warn (ev_warn),
    .ev_under (ev_under),
    .rst_req (rst_req)
  );

  wwd_cfgstat u_cfg (
    .clk (clk),
    .rst_n (rst_n),
    .cfg_wr (cfg_wr),
    .stat_wr (stat_wr),
    .wr_bound (bus_wdata[CNT_W-1:0]),
    .wr_ie (bus_wdata[IE_BIT]),
    .wr_sel (bus_wdata[SEL_LSB +: SEL_W]),
    .wr_flag (bus_wdata[FLAG_BIT]),
    .ev_warn (ev_warn),
    .bound (win),
    .ie (ie),
    .sel (sel),
    .flag (flag),
    .irq (irq)
  );

  always_comb begin
    case (word)
      W_CTRL:  bus_rdata = pack_ctrl(cnt, act);
      W_CFG:   bus_rdata = pack_cfg(win, ie, sel);
      W_STAT:  bus_rdata = pack_stat(flag);
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/window_watchdog_chk.sv
module window_watchdog_chk
  import wwd_pkg::*;
#(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          ctrl_wr,
  input cnt_t          cnt,
  input cnt_t          win,
  input logic          act,
  input logic          ie,
  input logic          flag,
  input logic          rst_req,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata
);

  a_r5_early_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && act && cnt > win) |=> rst_req);

  a_r5_request_source: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(ctrl_wr || tick));

  a_r6_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_wr && cnt == WARN_VAL) |=> (rst_req && cnt == cnt_t'(WARN_VAL - cnt_t'(1))));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_wr && cnt == PRE_WARN) |=> flag);

  a_r3_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> act);

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !ctrl_wr) |=> $stable(cnt));

  a_r9_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ie |=> ie);

  a_r10_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cnt == $past(bus_wdata[CNT_W-1:0])));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[AW-1:2] == (AW-2)'(CFG_WORD)) |-> (bus_rdata[IE_BIT-1:ACT_BIT] == 2'b00));

endmodule

bind window_watchdog window_watchdog_chk #(.AW(AW)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .tick (tick),
  .ctrl_wr (ctrl_wr),
  .cnt (cnt),
  .win (win),
  .act (act),
  .ie (ie),
  .flag (flag),
  .rst_req (rst_req),
  .bus_addr (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata)
);

// File: tb/window_watchdog_test.sv
`timescale 1ns/1ps
module window_watchdog_test;

  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req, irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  window_watchdog #(.DIV_BASE(DIV), .AW(4)) uut (
    .clk (clk), .rst_n (rst_n), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .rst_req (rst_req), .irq (irq)
  );

  // ---------------- behavioural reference ----------------
  int m_cnt, m_act, m_win, m_ie, m_sel, m_flag, m_pc, m_rst;

  function automatic int m_read(input logic [3:0] a);
    case (a[3:2])
      2'd0:    return m_cnt + (m_act * 128);
      2'd1:    return m_win + (m_ie * 512) + (m_sel * 1024);
      2'd2:    return m_flag;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 127; m_act = 0; m_win = 127; m_ie = 0;
      m_sel = 0; m_flag = 0; m_pc = 0; m_rst = 0;
    end else begin
      int lim, due, cw, fw, sw, nc, np, nf;
      lim = DIV * (1 << m_sel);
      due = (m_act != 0) && (m_pc >= lim - 1);
      cw  = bus_we && bus_addr[3:2] == 2'd0;
      fw  = bus_we && bus_addr[3:2] == 2'd1;
      sw  = bus_we && bus_addr[3:2] == 2'd2;
      np  = (m_act == 0 || due) ? 0 : m_pc + 1;
      nc  = cw ? int'(bus_wdata[6:0]) : (due ? ((m_cnt + 127) % 128) : m_cnt);
      nf  = m_flag;
      if (due && !cw && m_cnt == 65) nf = 1;
      else if (sw && !bus_wdata[0]) nf = 0;
      m_rst = ((cw && m_act != 0 && m_cnt > m_win) || (due && !cw && m_cnt == 64)) ? 1 : 0;
      if (cw && bus_wdata[7]) m_act = 1;
      if (fw) begin
        m_win = int'(bus_wdata[6:0]);
        m_sel = int'(bus_wdata[12:10]);
        if (bus_wdata[9]) m_ie = 1;
      end
      m_cnt = nc; m_pc = np; m_flag = nf;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // every cycle: outputs against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 or R6 rst_req per cycle", int'(rst_req), m_rst);
      chk("R9 irq per cycle", int'(irq), (m_flag != 0 && m_ie != 0) ? 1 : 0);
      chk("R2 read word per cycle", int'(bus_rdata), m_read(bus_addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(posedge clk); #2;
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  // cycles until the counter field next changes
  task automatic measure(output int n);
    logic [6:0] v0;
    @(posedge clk); #2;
    bus_addr = 4'h0;
    @(negedge clk);
    v0 = bus_rdata[6:0];
    n = 1;
    do begin
      @(negedge clk);
      n++;
    end while (bus_rdata[6:0] == v0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, n;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, v); chk("R1 control reset", v, 32'h7F);
    rd(4'h4, v); chk("R1 config reset", v, 32'h7F);
    rd(4'h8, v); chk("R1 status reset", v, 0);
    chk("R1 rst_req low", int'(rst_req), 0);
    chk("R1 irq low", int'(irq), 0);

    // R2 layout and reserved bits
    rd(4'hC, v); chk("R2 word 3 reads zero", v, 0);
    wr(4'h4, 32'h0000_0180 | 32'h50);
    rd(4'h4, v); chk("R2 config readback, bits 8:7 zero", v, 32'h50);

    // R3 frozen while inactive
    repeat (20) @(posedge clk);
    rd(4'h0, v); chk("R3 inactive counter holds", v, 32'h7F);

    // R4 activation and period
    wr(4'h0, 32'hFF);
    measure(n); chk("R4 first step after activation", n, DIV);
    measure(n); chk("R4 period sel 0", n, DIV);

    // R5 early rewrite, R3 active bit cannot be cleared
    wr(4'h0, 32'h45);
    @(negedge clk); chk("R5 early rewrite raises rst_req", int'(rst_req), 1);
    @(negedge clk); chk("R5 request lasts one cycle", int'(rst_req), 0);
    rd(4'h0, v); chk("R3 active bit stays set", (v >> 7) & 1, 1);
    chk("R5 early value still loaded", v & 32'h7F, m_cnt);

    // R5 rewrite inside window
    wr(4'h0, 32'h48);
    @(negedge clk); chk("R5 rewrite in window no request", int'(rst_req), 0);

    // R7 flag with interrupt disabled
    while (m_flag == 0) @(negedge clk);
    rd(4'h8, v); chk("R7 flag set at 0x40", v, 1);
    chk("R7 irq stays low when disabled", int'(irq), 0);

    // R6 underflow
    @(posedge clk); #2 bus_addr = 4'h0;
    do @(negedge clk); while (!rst_req);
    chk("R6 underflow counter value", int'(bus_rdata[6:0]), 32'h3F);
    @(negedge clk); chk("R6 request lasts one cycle", int'(rst_req), 0);

    // R8 clear semantics
    wr(4'h8, 32'h1);
    rd(4'h8, v); chk("R8 writing one leaves flag", v, 1);
    wr(4'h8, 32'h0);
    rd(4'h8, v); chk("R8 writing zero clears flag", v, 0);

    // R9 enable and irq
    wr(4'h4, 32'h250);
    rd(4'h4, v); chk("R9 enable readback", (v >> 9) & 1, 1);
    while (m_flag == 0) @(negedge clk);
    @(negedge clk); chk("R9 irq with flag and enable", int'(irq), 1);
    wr(4'h4, 32'h050);
    rd(4'h4, v); chk("R9 enable not cleared by zero", (v >> 9) & 1, 1);
    chk("R9 irq still high", int'(irq), 1);
    wr(4'h8, 32'h0);
    @(negedge clk); chk("R9 irq low after clear", int'(irq), 0);

    // R8 set beats clear on the same edge
    wr(4'h0, 32'h48);
    forever begin
      @(posedge clk); #2;
      if (m_act != 0 && m_pc == DIV * (1 << m_sel) - 1 && m_cnt == 65) begin
        bus_we = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h0;
        @(posedge clk); #2 bus_we = 1'b0;
        break;
      end
    end
    rd(4'h8, v); chk("R8 set wins over same-edge clear", v, 1);

    // R10 rewrite beats decrement on the same edge
    forever begin
      @(posedge clk); #2;
      if (m_act != 0 && m_pc == DIV * (1 << m_sel) - 1 && m_cnt <= m_win) break;
    end
    bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h4A;
    @(posedge clk); #2 bus_we = 1'b0;
    @(negedge clk); chk("R10 written value kept, no decrement", int'(bus_rdata[6:0]), 32'h4A);

    // R4 larger rate select
    wr(4'h4, 32'h250 | (32'd2 << 10));
    measure(n);
    measure(n); chk("R4 period sel 2", n, DIV * 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule